// File: doc/BRIEF.md
# Integer Operation Unit with Function Select Decoder

This block is the arithmetic core of a small load/store processor. It takes two 32-bit operands and returns one 32-bit result and a flag that is high when the result is all zeros. It has no clock and no state, so its outputs follow its inputs within the same cycle.

A decoder inside the block picks the operation. Its inputs are a 2-bit class code from the main controller and the 6-bit function field, which is the least significant field of a register-format instruction word. Memory accesses need an address sum, so they always get add. Branch-equal always gets subtract, and the zero flag then shows whether the operands are equal. For register-format instructions the function field chooses among the five operations.

The 3-bit select code that the decoder produces is also an output of the block. Its most significant bit inverts B and sets the adder's carry-in, which turns the adder into a subtractor. Its two low bits choose which unit drives the result: the AND unit, the OR unit, the adder, or the signed less-than unit.

Top module: `alu_fn_unit`

## Requirements
- R1: `op_sel_o` is always one of five codes: 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract, 3'b111 set-on-less-than.
- R2: Class 2'b00 (load/store) selects add, whatever the function field holds.
- R3: Class 2'b01 (branch-equal) selects subtract, whatever the function field holds.
- R4: When bit 1 of the class is set (2'b10 or 2'b11), function 6'b100000 selects add, 6'b100010 selects subtract, 6'b100100 selects AND, 6'b100101 selects OR and 6'b101010 selects set-on-less-than.
- R5: When bit 1 of the class is set, every other function code selects add.
- R6: Add returns A + B modulo 2^32. The carry out is dropped.
- R7: Subtract returns A - B modulo 2^32.
- R8: AND returns the bitwise AND of A and B, and OR returns their bitwise OR.
- R9: Set-on-less-than treats both operands as two's-complement signed values. It returns 32'h1 when A < B and 32'h0 otherwise, and the answer stays correct when A - B overflows.
- R10: `zero_o` is 1 exactly when `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Operation class from the main controller |
| funct_i | input | 6 | Function field of a register-format instruction |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_sel_o | output | 3 | Decoded operation select |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is zero |

## Verification
The embedded assertions are evaluated whenever the inputs change. They check that every result is arithmetically consistent with its operands, whatever the operand values:
- a sum minus B gives back A;
- a difference plus B gives back A;
- an OR result covers every set bit of both operands;
- a less-than result equals a signed comparison made apart from the adder.

They also check that load/store class always yields add. Only the bench's scenarios can show the following:
- the full mapping from class and function code to select, including every unused function code and class 2'b11;
- the overflow corners of the signed comparison at the two ends of the signed range;
- the zero flag on results that are exactly zero.

// File: rtl/alu_fn_pkg.sv
package alu_fn_pkg;
  localparam int unsigned CLASS_W = 2;
  localparam int unsigned FUNCT_W = 6;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alu_sel_e;

  // low two bits of the select pick the result source
  typedef enum logic [1:0] {
    SRC_AND = 2'b00,
    SRC_OR  = 2'b01,
    SRC_SUM = 2'b10,
    SRC_LT  = 2'b11
  } res_src_e;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM = 2'b00,
    CLS_BEQ = 2'b01,
    CLS_REG = 2'b10,
    CLS_RG2 = 2'b11
  } op_class_e;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_fn_decoder.sv
module alu_fn_decoder
  import alu_fn_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class_i,
  input  logic [FUNCT_W-1:0] funct_i,
  output alu_sel_e           sel_o
);
  alu_sel_e fn_sel;

  always_comb begin
    unique case (funct_i)
      FN_SUB:  fn_sel = SEL_SUB;
      FN_AND:  fn_sel = SEL_AND;
      FN_OR:   fn_sel = SEL_OR;
      FN_SLT:  fn_sel = SEL_SLT;
      default: fn_sel = SEL_ADD;
    endcase
  end

  always_comb begin
    if (op_class_i[1])                sel_o = fn_sel;
    else if (op_class_i == CLS_BEQ)   sel_o = SEL_SUB;
    else                              sel_o = SEL_ADD;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             neg_b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_out;
  logic             c_msb;

  assign b_eff = b_i ^ {WIDTH{neg_b_i}};
  assign {c_out, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, neg_b_i};
  // carry into the top bit, recovered from the sum bit
  assign c_msb = a_i[MSB] ^ b_eff[MSB] ^ sum_o[MSB];
  assign ovf_o = c_msb ^ c_out;
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_fn_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] and_w, or_w, sum_w, lt_w;
  logic             ovf_w;
  res_src_e         src;

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w)
  );

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i     (a_i),
    .b_i     (b_i),
    .neg_b_i (sel_i[SEL_W-1]),
    .sum_o   (sum_w),
    .ovf_o   (ovf_w)
  );

  // signed less-than: sign of difference, flipped on overflow
  assign lt_w = {{(WIDTH-1){1'b0}}, sum_w[MSB] ^ ovf_w};
  assign src  = res_src_e'(sel_i[1:0]);

  always_comb begin
    unique case (src)
      SRC_AND: result_o = and_w;
      SRC_OR:  result_o = or_w;
      SRC_SUM: result_o = sum_w;
      default: result_o = lt_w;
    endcase
  end

  always_comb begin
    if (sel_i == SEL_ADD)
      p_add_inverse_r6: assert (result_o - b_i == a_i)
        else $error("add result inconsistent");
    if (sel_i == SEL_SUB)
      p_sub_inverse_r7: assert (result_o + b_i == a_i)
        else $error("sub result inconsistent");
    if (sel_i == SEL_OR)
      p_or_cover_r8: assert (((a_i | b_i) & ~result_o) == '0)
        else $error("or result misses operand bits");
    if (sel_i == SEL_SLT)
      p_slt_signed_r9: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
        else $error("slt result wrong");
  end
endmodule

// File: rtl/alu_fn_unit.sv
module alu_fn_unit
  import alu_fn_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op_class_i,
  input  logic [5:0]       funct_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [2:0]       op_sel_o,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o
);
  alu_sel_e sel_w;

  alu_fn_decoder u_dec (
    .op_class_i (op_class_i),
    .funct_i    (funct_i),
    .sel_o      (sel_w)
  );

  assign op_sel_o = sel_w;

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_i    (op_sel_o),
    .result_o (result_o)
  );

  assign zero_o = ~|result_o;

  always_comb begin
    if (op_class_i == CLS_MEM)
      p_mem_add_r2: assert (op_sel_o == SEL_ADD)
        else $error("memory class not add");
    if (op_class_i == CLS_BEQ)
      p_beq_sub_r3: assert (op_sel_o == SEL_SUB)
        else $error("branch class not sub");
  end
endmodule

// File: tb/alu_fn_unit_tb.sv
module alu_fn_unit_tb;
  logic        clk = 1'b0;
  logic [1:0]  op_class;
  logic [5:0]  funct;
  logic [31:0] a, b;
  logic [2:0]  op_sel;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0]  sel;
    logic [31:0] res;
    logic        zf;
    string       tag;
  } item_t;

  item_t sb_q[$];

  always #5 clk = ~clk;

  alu_fn_unit u_dut (
    .op_class_i (op_class),
    .funct_i    (funct),
    .a_i        (a),
    .b_i        (b),
    .op_sel_o   (op_sel),
    .result_o   (result),
    .zero_o     (zero)
  );

  function automatic logic [2:0] model_sel(logic [1:0] c, logic [5:0] f);
    if (c == 2'b00) return 3'b010;
    if (c == 2'b01) return 3'b110;
    case (f)
      6'b100000: return 3'b010;
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  function automatic logic [31:0] model_res(logic [2:0] s, logic [31:0] x, logic [31:0] y);
    case (s)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return x + y;
      3'b110:  return x - y;
      default: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic drive(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] x, input logic [31:0] y, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    op_class = c; funct = f; a = x; b = y;
    it.sel = model_sel(c, f);
    it.res = model_res(it.sel, x, y);
    it.zf  = (it.res == 32'd0);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (op_sel !== it.sel || result !== it.res || zero !== it.zf) begin
        n_fail++;
        $display("FAIL %s: sel=%b res=%h zero=%b expected sel=%b res=%h zero=%b",
                 it.tag, op_sel, result, zero, it.sel, it.res, it.zf);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] lfsr;
    op_class = 2'b00; funct = 6'd0; a = 32'd0; b = 32'd0;
    // initial all-zero inputs: add of zeros, zero flag set (R2, R10)
    drive(2'b00, 6'd0, 32'd0, 32'd0, "R2_R10_idle");
    // R2: memory class adds regardless of funct
    drive(2'b00, 6'b100010, 32'h0000_1000, 32'h0000_0064, "R2_mem_add");
    drive(2'b00, 6'b101010, 32'hFFFF_FFFC, 32'h0000_0008, "R2_mem_neg_offset");
    // R3: branch class subtracts; equal operands give zero (R10)
    drive(2'b01, 6'b100100, 32'h1234_5678, 32'h1234_5678, "R3_R10_beq_equal");
    drive(2'b01, 6'b100000, 32'h1234_5678, 32'h1234_5677, "R3_beq_diff");
    // R4: each defined function code, both register classes
    for (int k = 0; k < 2; k++) begin
      logic [1:0] c;
      c = (k == 0) ? 2'b10 : 2'b11;
      drive(c, 6'b100000, 32'h0F0F_0F0F, 32'h3333_3333, "R4_add");
      drive(c, 6'b100010, 32'h0F0F_0F0F, 32'h3333_3333, "R4_sub");
      drive(c, 6'b100100, 32'h0F0F_0F0F, 32'h3333_3333, "R4_and");
      drive(c, 6'b100101, 32'h0F0F_0F0F, 32'h3333_3333, "R4_or");
      drive(c, 6'b101010, 32'h0F0F_0F0F, 32'h3333_3333, "R4_slt");
    end
    // R5: all 64 function codes under class 10; R1 code set via model
    for (int f = 0; f < 64; f++)
      drive(2'b10, 6'(f), 32'hA5A5_0001, 32'h5A5A_0003, "R5_R1_funct_sweep");
    // R6: wraparound
    drive(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001, "R6_R10_add_wrap");
    drive(2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, "R6_add_signed_ovf");
    // R7: borrow cases
    drive(2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001, "R7_sub_borrow");
    drive(2'b10, 6'b100010, 32'h8000_0000, 32'h0000_0001, "R7_sub_ovf");
    // R8: logic with extreme patterns; AND to zero sets flag (R10)
    drive(2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555, "R8_R10_and_disjoint");
    drive(2'b10, 6'b100101, 32'hAAAA_AAAA, 32'h5555_5555, "R8_or_full");
    drive(2'b10, 6'b100101, 32'h0000_0000, 32'h0000_0000, "R8_R10_or_zero");
    // R9: signed corners, incl. overflowing differences
    drive(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, "R9_min_lt_pos");
    drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9_max_vs_neg1");
    drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R9_max_vs_min");
    drive(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R9_min_vs_max");
    drive(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0000, "R9_neg1_lt_0");
    drive(2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0005, "R9_R10_equal");
    // pseudo-random operands across all ops (R6 R7 R8 R9)
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] x, y;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      x = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      y = lfsr;
      case (n % 5)
        0: drive(2'b10, 6'b100000, x, y, "R6_rand_add");
        1: drive(2'b10, 6'b100010, x, y, "R7_rand_sub");
        2: drive(2'b10, 6'b100100, x, y, "R8_rand_and");
        3: drive(2'b10, 6'b100101, x, y, "R8_rand_or");
        default: drive(2'b10, 6'b101010, x, y, "R9_rand_slt");
      endcase
    end
    repeat (3) @(posedge clk);
    finished = 1'b1;
    summary();
  end
endmodule